// File: doc/BRIEF.md
# Same-Index Routing Switch Box

This block models a programmable switch box at the crossing of a horizontal and a vertical routing channel. Each of its four sides (north, east, south, west) carries `W` tracks. A track can be joined only to the track with the same index on each of the other three sides, so each wire that enters the box has exactly three switches. Each two-way pass switch is modelled as a pair of directed drivers. Every side therefore has an input bus and an output bus of `W` bits. Segments end at the box, and a longer path is made by turning on switches in successive boxes.

Each track has six side-pair switches, so the box holds `6*W` configuration bits. They are loaded through a serial chain. A small state machine has two states. `ST_ROUTE` drives the switch paths. `ST_LOAD` blanks every output while bits are moving through the chain. The transition `ROUTE->LOAD` is taken at an edge where `cfg_shift` is high. The transition `LOAD->ROUTE` is taken at an edge where `cfg_shift` is low. Reset enters `ST_ROUTE` with every switch off. The switch paths themselves are purely combinational.

Top module: `sbox_disjoint`

## Requirements
- R1: After reset, every configuration bit is 0, the state is `ST_ROUTE`, and every output is 0 whatever the inputs are.
- R2: At each rising edge with `cfg_shift` high, one bit is taken from `cfg_din`. After `6*W` such edges, the k-th bit shifted in (counting from 0) sets switch `p` of track `t`, where `k = 6*t + p`. Switch 0 joins N-E, 1 joins N-S, 2 joins N-W, 3 joins E-S, 4 joins E-W and 5 joins S-W.
- R3: From the first edge with `cfg_shift` high until the first later edge with `cfg_shift` low, every output bit is 0.
- R4: In `ST_ROUTE`, output bit t of a side is the OR of input bit t of each other side whose switch to this side is on.
- R5: Turning on a side-pair switch passes a signal both ways between its two sides.
- R6: The input of a side never reaches the output of the same side, even with all of that track's switches on.
- R7: Track t never drives an output of a different track index.
- R8: While `cfg_shift` is low, the configuration is held whatever `cfg_din` does.
- R9: An output whose three switches are all off is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_shift | input | 1 | Shift one configuration bit per edge |
| cfg_din | input | 1 | Serial configuration data |
| n_in | input | W | North side track inputs |
| e_in | input | W | East side track inputs |
| s_in | input | W | South side track inputs |
| w_in | input | W | West side track inputs |
| n_out | output | W | North side track outputs |
| e_out | output | W | East side track outputs |
| s_out | output | W | South side track outputs |
| w_out | output | W | West side track outputs |

## Verification
The bench builds the box with the default `W = 4`, which gives a 24-bit chain. That width is large enough to place a fully switched track between two tracks that have no switches on. With that arrangement, isolation between track indices shows at the outputs. All six switch positions appear in each track word, so a bit placed in the wrong slot of the chain changes a visible output. The bench also sets a configuration that mixes patterns across tracks and drives several input patterns through it, checking the OR merging against a model built from the requirements.

// File: rtl/sbox_pkg.sv
package sbox_pkg;
    typedef enum logic {
        ST_ROUTE = 1'b0,
        ST_LOAD  = 1'b1
    } sbox_state_e;

    localparam int PAIRS = 6;
    localparam int P_NE = 0;
    localparam int P_NS = 1;
    localparam int P_NW = 2;
    localparam int P_ES = 3;
    localparam int P_EW = 4;
    localparam int P_SW = 5;
endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int LEN = 24
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift,
    input  logic           din,
    output logic [LEN-1:0] bits
);
    logic [LEN-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else if (shift) begin
            chain_q <= {din, chain_q[LEN-1:1]};
        end
    end

    assign bits = chain_q;

    // R8: configuration holds while not shifting
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(bits));

    // R2: the newest bit sits at the head of the chain
    p_head_r2: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> bits[LEN-1] == $past(din));
endmodule

// File: rtl/sbox_track_cell.sv
module sbox_track_cell
    import sbox_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate,
    input  logic [PAIRS-1:0] sw,
    input  logic             n_i,
    input  logic             e_i,
    input  logic             s_i,
    input  logic             w_i,
    output logic             n_o,
    output logic             e_o,
    output logic             s_o,
    output logic             w_o
);
    always_comb begin
        n_o = gate & ((e_i & sw[P_NE]) | (s_i & sw[P_NS]) | (w_i & sw[P_NW]));
        e_o = gate & ((n_i & sw[P_NE]) | (s_i & sw[P_ES]) | (w_i & sw[P_EW]));
        s_o = gate & ((n_i & sw[P_NS]) | (e_i & sw[P_ES]) | (w_i & sw[P_SW]));
        w_o = gate & ((n_i & sw[P_NW]) | (e_i & sw[P_EW]) | (s_i & sw[P_SW]));
    end

    // R5: an enabled N-E switch carries a signal in both directions
    p_sym_ne_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && sw[P_NE] && n_i) |-> e_o);
    p_sym_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gate && sw[P_NE] && e_i) |-> n_o);

    // R9: a north output whose three switches are off stays low
    p_idle_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sw[P_NE] == 1'b0 && sw[P_NS] == 1'b0 && sw[P_NW] == 1'b0) |-> !n_o);

    // R6: only the north input high cannot raise the north output
    p_noloop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (n_i && !e_i && !s_i && !w_i) |-> !n_o);
endmodule

// File: rtl/sbox_disjoint.sv
module sbox_disjoint
    import sbox_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_shift,
    input  logic         cfg_din,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] e_in,
    input  logic [W-1:0] s_in,
    input  logic [W-1:0] w_in,
    output logic [W-1:0] n_out,
    output logic [W-1:0] e_out,
    output logic [W-1:0] s_out,
    output logic [W-1:0] w_out
);
    localparam int CFG_LEN = PAIRS * W;

    sbox_state_e         state_q;
    sbox_state_e         state_d;
    logic                route_en;
    logic [CFG_LEN-1:0]  cfg_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ROUTE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ROUTE: if (cfg_shift)  state_d = ST_LOAD;
            ST_LOAD:  if (!cfg_shift) state_d = ST_ROUTE;
            default:  state_d = ST_ROUTE;
        endcase
    end

    always_comb begin
        route_en = 1'b0;
        unique case (state_q)
            ST_ROUTE: route_en = 1'b1;
            ST_LOAD:  route_en = 1'b0;
            default:  route_en = 1'b0;
        endcase
    end

    sbox_cfg_chain #(.LEN(CFG_LEN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (cfg_shift),
        .din   (cfg_din),
        .bits  (cfg_bits)
    );

    for (genvar t = 0; t < W; t++) begin : g_track
        sbox_track_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .gate  (route_en),
            .sw    (cfg_bits[t*PAIRS +: PAIRS]),
            .n_i   (n_in[t]),
            .e_i   (e_in[t]),
            .s_i   (s_in[t]),
            .w_i   (w_in[t]),
            .n_o   (n_out[t]),
            .e_o   (e_out[t]),
            .s_o   (s_out[t]),
            .w_o   (w_out[t])
        );
    end

    // R3: a shifting edge enters the blanked state
    p_enter_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> state_q == ST_LOAD);

    // R3: no output is driven while loading
    p_load_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_LOAD |-> (n_out == '0 && e_out == '0 && s_out == '0 && w_out == '0));

    // R3: a quiet edge returns to routing
    p_exit_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_shift |=> state_q == ST_ROUTE);
endmodule

// File: tb/sbox_disjoint_tb.sv
module sbox_disjoint_tb;
    localparam int W = 4;
    localparam int N = 6 * W;
    localparam time CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_shift = 1'b0;
    logic cfg_din = 1'b0;
    logic [W-1:0] n_in = '0, e_in = '0, s_in = '0, w_in = '0;
    logic [W-1:0] n_out, e_out, s_out, w_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbox_disjoint #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_din(cfg_din),
        .n_in(n_in), .e_in(e_in), .s_in(s_in), .w_in(w_in),
        .n_out(n_out), .e_out(e_out), .s_out(s_out), .w_out(w_out)
    );

    function automatic logic [4*W-1:0] model(input logic [N-1:0] c,
        input logic [W-1:0] n, input logic [W-1:0] e,
        input logic [W-1:0] s, input logic [W-1:0] w);
        logic [W-1:0] no, eo, so, wo;
        for (int t = 0; t < W; t++) begin
            logic [5:0] p;
            p = c[6*t +: 6];
            no[t] = (e[t] & p[0]) | (s[t] & p[1]) | (w[t] & p[2]);
            eo[t] = (n[t] & p[0]) | (s[t] & p[3]) | (w[t] & p[4]);
            so[t] = (n[t] & p[1]) | (e[t] & p[3]) | (w[t] & p[5]);
            wo[t] = (n[t] & p[2]) | (e[t] & p[4]) | (s[t] & p[5]);
        end
        return {no, eo, so, wo};
    endfunction

    task automatic check(input string req, input logic [4*W-1:0] got, input logic [4*W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic drive(input logic [W-1:0] n, input logic [W-1:0] e,
                         input logic [W-1:0] s, input logic [W-1:0] w);
        @(negedge clk);
        n_in = n; e_in = e; s_in = s; w_in = w;
        #1;
    endtask

    task automatic load(input logic [N-1:0] c);
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_din = c[k];
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        cfg_din = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_reset;
        drive('1, '1, '1, '1);
        check("R1 reset outputs", {n_out, e_out, s_out, w_out}, '0);
    endtask

    task automatic t_single_pair;
        logic [N-1:0] c = '0;
        c[0] = 1'b1; // track 0 N-E
        load(c);
        drive(4'b0001, '0, '0, '0);
        check("R2/R5 N to E", {n_out, e_out, s_out, w_out}, model(c, 4'b0001, '0, '0, '0));
        check("R5 N to E bit", {12'b0, e_out}, {12'b0, 4'b0001});
        drive('0, 4'b0001, '0, '0);
        check("R5 E to N", {n_out, e_out, s_out, w_out}, {4'b0001, 12'b0});
        drive('0, '0, 4'b0001, 4'b0001);
        check("R9 unswitched sides", {n_out, e_out, s_out, w_out}, '0);
    endtask

    task automatic t_positions;
        for (int p = 0; p < 6; p++) begin
            logic [N-1:0] c = '0;
            c[6*3 + p] = 1'b1;
            load(c);
            drive(4'b1000, 4'b1000, 4'b1000, 4'b1000);
            check($sformatf("R2 track3 switch %0d", p), {n_out, e_out, s_out, w_out},
                  model(c, 4'b1000, 4'b1000, 4'b1000, 4'b1000));
        end
    endtask

    task automatic t_loop_and_isolation;
        logic [N-1:0] c = '0;
        c[6*1 +: 6] = 6'b111111;
        load(c);
        drive(4'b0010, '0, '0, '0);
        check("R6 no N loopback", {28'b0, n_out}, 32'b0);
        check("R6 N to three sides", {n_out, e_out, s_out, w_out}, {4'b0, 4'b0010, 4'b0010, 4'b0010});
        drive(4'b1101, 4'b1101, 4'b1101, 4'b1101);
        check("R7 other tracks isolated", {n_out, e_out, s_out, w_out}, '0);
    endtask

    task automatic t_or_merge;
        logic [N-1:0] c = 24'hA5C3_96;
        logic [W-1:0] pats [4] = '{4'h3, 4'hC, 4'h9, 4'hF};
        load(c);
        for (int i = 0; i < 4; i++) begin
            for (int j = 0; j < 4; j++) begin
                drive(pats[i], pats[j], pats[(i+j)%4], pats[(i+1)%4]);
                check("R4 OR merge", {n_out, e_out, s_out, w_out},
                      model(c, pats[i], pats[j], pats[(i+j)%4], pats[(i+1)%4]));
            end
        end
    endtask

    task automatic t_blank_during_load;
        drive('1, '1, '1, '1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            cfg_shift = 1'b1;
            cfg_din = 1'b1;
        end
        #1;
        check("R3 blank while shifting", {n_out, e_out, s_out, w_out}, '0);
        for (int k = 3; k < N; k++) begin
            @(negedge clk);
            cfg_din = 1'b1;
        end
        @(negedge clk);
        cfg_shift = 1'b0;
        #1;
        check("R3 still blank before quiet edge", {n_out, e_out, s_out, w_out}, '0);
        @(posedge clk);
        #1;
        check("R3 routes after quiet edge", {n_out, e_out, s_out, w_out},
              model('1, '1, '1, '1, '1));
    endtask

    task automatic t_hold;
        logic [N-1:0] c = 24'h0_41_20_8;
        load(c);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cfg_din = k[0];
        end
        drive(4'b0110, 4'b1010, 4'b0101, 4'b1001);
        check("R8 held config", {n_out, e_out, s_out, w_out},
              model(c, 4'b0110, 4'b1010, 4'b0101, 4'b1001));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single_pair();
        t_positions();
        t_loop_and_isolation();
        t_or_merge();
        t_blank_during_load();
        t_hold();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule